// File: doc/BRIEF.md
# Clock-Owning Serial Byte Transmitter for Receiver Stress Tests

This block sends bytes to a receiver over two push-pull lines: a serial clock that the block generates itself, and a data line that the receiver samples on the rising edge of that clock. It exists to push a receiver towards its maximum shift rate. The data-bit clock period is set exactly by a programmable count of system cycles. Because the transmitter owns the clock, the start and stop bits can be sent with a slower clock than the data bits, and a quiet pause can be added after each byte.

Bytes arrive on a valid/ready handshake. Each byte goes out as a frame of ten bits: a low start bit, eight data bits starting with the least significant, and a high stop bit. Each bit is one clock pulse: the clock goes low, and the data line changes at that moment. After half a bit period the clock goes high, and the receiver samples on this rising edge. A test input replaces the byte with all ones, so that every frame has exactly one low pulse on the data line, the start bit. The timing settings and the byte are captured when a byte is accepted, so later changes wait for the next frame.

The sequencer has four states. ST_IDLE holds both lines high with ready asserted. Its transition *accept* leads to ST_LOW. ST_LOW is the low half of a bit; *low_done* leads to ST_HIGH. ST_HIGH is the high half of a bit. From ST_HIGH, *next_bit* returns to ST_LOW for the next bit of the frame. After the stop bit, *stop_to_gap* leads to ST_GAP when a pause is set, and *stop_to_idle* leads to ST_IDLE when it is not. ST_GAP holds both lines high with ready low, and *gap_done* leads to ST_IDLE.

Top module: `clkser_tx`

## Requirements
- R1: During and right after reset, ser_clk and ser_data are 1 and in_ready is 1.
- R2: Each accepted byte is sent as ten bits in this order: start bit 0, data bits 0 to 7 (LSB first), stop bit 1. Each bit is one clock pulse: ser_clk low for one phase, then high for one phase, with ser_data holding the bit value for both phases.
- R3: Each data-bit phase (low or high) lasts H system cycles. H is cfg_half, and a value of 0 counts as 1.
- R4: Each phase of the start bit and of the stop bit lasts H·2^S cycles. S is cfg_stretch for values 0 to 4, and any value above 4 counts as 4 (factors 1, 2, 4, 8, 16).
- R5: ser_data changes only in the cycle where ser_clk goes low, or when it returns to idle. It is constant while ser_clk stays high.
- R6: After the high phase of the stop bit, the lines stay high with in_ready low for exactly G cycles, where G is cfg_gap. After that, in_ready rises.
- R7: in_ready is 1 only while idle. A byte is taken on a clock edge where in_valid and in_ready are both 1, and the first low cycle of the start bit follows that edge directly. in_valid has no effect while in_ready is 0.
- R8: When test_ones is 1 at acceptance, the data bits are all 1 regardless of in_data.
- R9: Changes to in_data, test_ones, cfg_half, cfg_stretch or cfg_gap after acceptance do not affect the frame or the gap in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Byte to send |
| in_ready | output | 1 | Transmitter idle, byte will be taken |
| test_ones | input | 1 | Send all-ones byte instead of in_data |
| cfg_half | input | HW (8) | Data-bit half period in system cycles |
| cfg_stretch | input | SW (3) | Start/stop period multiplier exponent |
| cfg_gap | input | GW (8) | Idle cycles after each stop bit |
| ser_clk | output | 1 | Serial clock, idle high |
| ser_data | output | 1 | Serial data, idle high |

## Verification
A wrong count in the phase timer shows up as a clock phase that is too long or too short. This is visible at ser_clk within one bit period, and every later edge of the frame is shifted as well. A bit index or shift register that is out of step gives a wrong ser_data level, a missing or extra clock pulse, or a start or stop phase with the wrong length, all seen within the same frame. Configuration registers that are not properly held show up as timing changing in the middle of a frame right after the inputs are scrambled. The bench therefore compares all three outputs against a cycle-level model on every clock.

// File: rtl/clkser_pkg.sv
package clkser_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOW,
        ST_HIGH,
        ST_GAP
    } tx_state_t;

    localparam int FRAME_BITS = 10;
endpackage

// File: rtl/clkser_cfg.sv
module clkser_cfg #(
    parameter int HW      = 8,
    parameter int GW      = 8,
    parameter int SW      = 3,
    parameter int STR_MAX = 4,
    parameter int CW      = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          accept,
    input  logic [HW-1:0] cfg_half,
    input  logic [SW-1:0] cfg_stretch,
    input  logic [GW-1:0] cfg_gap,
    output logic [CW-1:0] data_len,
    output logic [CW-1:0] edge_len,
    output logic [CW-1:0] gap_len
);
    localparam int LW  = HW + STR_MAX;
    localparam int SQW = $clog2(STR_MAX + 1);

    logic [HW-1:0]  half_q, half_n, half_in;
    logic [SQW-1:0] str_q, str_n, str_in;
    logic [GW-1:0]  gap_q, gap_n;
    logic [LW-1:0]  scaled [0:STR_MAX];

    always_comb begin
        half_in = (cfg_half == '0) ? HW'(1) : cfg_half;
        str_in  = (cfg_stretch > SW'(STR_MAX)) ? SQW'(STR_MAX) : SQW'(cfg_stretch);
        half_n  = accept ? half_in : half_q;
        str_n   = accept ? str_in  : str_q;
        gap_n   = accept ? cfg_gap : gap_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            half_q <= HW'(1);
            str_q  <= '0;
            gap_q  <= '0;
        end else if (accept) begin
            half_q <= half_in;
            str_q  <= str_in;
            gap_q  <= cfg_gap;
        end
    end

    for (genvar k = 0; k <= STR_MAX; k++) begin : g_scale
        assign scaled[k] = LW'(half_n) << k;
    end

    assign data_len = CW'(scaled[0]);
    assign edge_len = CW'(scaled[str_n]);
    assign gap_len  = CW'(gap_n);

    // R9: captured settings move only on acceptance
    a_r9_settings_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        !accept |=> ($stable(half_q) && $stable(str_q) && $stable(gap_q)));
endmodule

// File: rtl/clkser_timer.sv
module clkser_timer #(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [CW-1:0] load_val,
    output logic          done
);
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (load)
            cnt <= load_val;
        else if (cnt != '0)
            cnt <= cnt - CW'(1);
    end

    assign done = (cnt == '0);

    // R3: phase counter falls by one per cycle when not reloaded
    a_r3_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt != '0) |=> (cnt == $past(cnt) - CW'(1)));
endmodule

// File: rtl/clkser_fsm.sv
module clkser_fsm
    import clkser_pkg::*;
#(
    parameter int CW = 12
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    input  logic          test_ones,
    input  logic          done,
    input  logic [CW-1:0] data_len,
    input  logic [CW-1:0] edge_len,
    input  logic [CW-1:0] gap_len,
    output logic          accept,
    output logic          load,
    output logic [CW-1:0] load_val,
    output logic          in_ready,
    output logic          ser_clk,
    output logic          ser_data
);
    localparam int IW = $clog2(FRAME_BITS);
    localparam logic [IW-1:0] LAST = IW'(FRAME_BITS - 1);

    tx_state_t             state, nstate;
    logic [IW-1:0]         bit_idx;
    logic [FRAME_BITS-1:0] shreg;
    logic                  is_last;
    logic [CW-1:0]         cur_len, nxt_len;

    assign accept  = in_valid && (state == ST_IDLE);
    assign is_last = (bit_idx == LAST);
    assign cur_len = (bit_idx == '0 || is_last) ? edge_len : data_len;
    assign nxt_len = (bit_idx + IW'(1) == LAST) ? edge_len : data_len;

    always_comb begin
        nstate   = state;
        load     = 1'b0;
        load_val = '0;
        unique case (state)
            ST_IDLE: if (accept) begin
                nstate   = ST_LOW;
                load     = 1'b1;
                load_val = edge_len - CW'(1);
            end
            ST_LOW: if (done) begin
                nstate   = ST_HIGH;
                load     = 1'b1;
                load_val = cur_len - CW'(1);
            end
            ST_HIGH: if (done) begin
                if (!is_last) begin
                    nstate   = ST_LOW;
                    load     = 1'b1;
                    load_val = nxt_len - CW'(1);
                end else if (gap_len != '0) begin
                    nstate   = ST_GAP;
                    load     = 1'b1;
                    load_val = gap_len - CW'(1);
                end else begin
                    nstate = ST_IDLE;
                end
            end
            ST_GAP: if (done) nstate = ST_IDLE;
            default: nstate = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            bit_idx <= '0;
            shreg   <= '1;
        end else begin
            state <= nstate;
            if (accept) begin
                bit_idx <= '0;
                shreg   <= {1'b1, (test_ones ? 8'hFF : in_data), 1'b0};
            end else if (state == ST_HIGH && done && !is_last) begin
                bit_idx <= bit_idx + IW'(1);
                shreg   <= {1'b1, shreg[FRAME_BITS-1:1]};
            end
        end
    end

    always_comb begin
        in_ready = (state == ST_IDLE);
        ser_clk  = (state != ST_LOW);
        ser_data = (state == ST_LOW || state == ST_HIGH) ? shreg[0] : 1'b1;
    end

    // R2: start bit drives both lines low right after acceptance
    a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (!ser_clk && !ser_data));

    // R5: data steady while the clock stays high
    a_r5_data_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk && $past(ser_clk)) |-> $stable(ser_data));

    // R7: ready only with idle lines
    a_r7_ready_idle: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> (ser_clk && ser_data));

    // R6: frame ends only after the stop bit
    a_r6_frame_end: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_HIGH && state != ST_LOW && state != ST_HIGH) |-> ($past(bit_idx) == LAST));
endmodule

// File: rtl/clkser_tx.sv
module clkser_tx #(
    parameter int HW      = 8,
    parameter int GW      = 8,
    parameter int SW      = 3,
    parameter int STR_MAX = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_valid,
    input  logic [7:0]    in_data,
    output logic          in_ready,
    input  logic          test_ones,
    input  logic [HW-1:0] cfg_half,
    input  logic [SW-1:0] cfg_stretch,
    input  logic [GW-1:0] cfg_gap,
    output logic          ser_clk,
    output logic          ser_data
);
    localparam int LW = HW + STR_MAX;
    localparam int CW = (LW > GW) ? LW : GW;

    logic          accept, load, done;
    logic [CW-1:0] load_val, data_len, edge_len, gap_len;

    clkser_cfg #(.HW(HW), .GW(GW), .SW(SW), .STR_MAX(STR_MAX), .CW(CW)) u_cfg (
        .clk(clk), .rst_n(rst_n), .accept(accept),
        .cfg_half(cfg_half), .cfg_stretch(cfg_stretch), .cfg_gap(cfg_gap),
        .data_len(data_len), .edge_len(edge_len), .gap_len(gap_len)
    );

    clkser_timer #(.CW(CW)) u_timer (
        .clk(clk), .rst_n(rst_n), .load(load), .load_val(load_val), .done(done)
    );

    clkser_fsm #(.CW(CW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .test_ones(test_ones), .done(done), .data_len(data_len),
        .edge_len(edge_len), .gap_len(gap_len), .accept(accept), .load(load),
        .load_val(load_val), .in_ready(in_ready), .ser_clk(ser_clk),
        .ser_data(ser_data)
    );
endmodule

// File: tb/sim_clkser_tx.sv
`timescale 1ns/1ps
module sim_clkser_tx;
    logic       clk = 0;
    logic       rst_n = 0;
    logic       in_valid = 0;
    logic [7:0] in_data = 0;
    logic       in_ready;
    logic       test_ones = 0;
    logic [7:0] cfg_half = 1;
    logic [2:0] cfg_stretch = 0;
    logic [7:0] cfg_gap = 0;
    logic       ser_clk, ser_data;

    int checks = 0;
    int errors = 0;
    bit finished = 0;
    bit exp_ready = 1;
    bit scramble_flag = 0;
    bit prev_clk_hi = 0;
    bit prev_data = 1;

    logic [2:0] eq[$];
    int         tq[$];

    always #5 clk = ~clk;

    clkser_tx u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .test_ones(test_ones), .cfg_half(cfg_half),
        .cfg_stretch(cfg_stretch), .cfg_gap(cfg_gap), .ser_clk(ser_clk),
        .ser_data(ser_data)
    );

    function automatic string tagname(int t);
        case (t)
            1: return "R1";
            2: return "R2";
            3: return "R3";
            4: return "R4";
            5: return "R5";
            6: return "R6";
            8: return "R8";
            9: return "R9";
            default: return "R7";
        endcase
    endfunction

    // Reference model: expand one accepted byte into per-cycle {ready,clk,data}
    always @(posedge clk) begin
        if (!rst_n) begin
            eq.delete();
            tq.delete();
        end else if (in_valid && exp_ready) begin
            int h, s, f, len, tg;
            logic [7:0] b;
            logic bv;
            h = (cfg_half == 0) ? 1 : int'(cfg_half);
            s = (cfg_stretch > 4) ? 4 : int'(cfg_stretch);
            f = 1 << s;
            b = test_ones ? 8'hFF : in_data;
            for (int i = 0; i < 10; i++) begin
                bv  = (i == 0) ? 1'b0 : (i == 9) ? 1'b1 : b[i-1];
                len = (i == 0 || i == 9) ? h * f : h;
                if (scramble_flag) tg = 9;
                else if (i == 0 || i == 9) tg = 4;
                else if (test_ones) tg = 8;
                else tg = 3;
                for (int k = 0; k < len; k++) begin eq.push_back({2'b00, bv}); tq.push_back(tg); end
                for (int k = 0; k < len; k++) begin eq.push_back({2'b01, bv}); tq.push_back(tg); end
            end
            for (int k = 0; k < int'(cfg_gap); k++) begin
                eq.push_back(3'b011); tq.push_back(scramble_flag ? 9 : 6);
            end
        end
    end

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic [2:0] e;
            int t;
            if (eq.size() > 0) begin
                e = eq.pop_front(); t = tq.pop_front(); exp_ready = 0;
            end else begin
                e = 3'b111; t = 7; exp_ready = 1;
            end
            checks++;
            if ({in_ready, ser_clk, ser_data} !== e) begin
                errors++;
                $display("FAIL %s cycle check: {ready,clk,data} actual %b expected %b at %0t",
                         tagname(t), {in_ready, ser_clk, ser_data}, e, $time);
            end
            // R5: data constant across consecutive clock-high cycles
            if (prev_clk_hi && ser_clk) begin
                checks++;
                if (ser_data !== prev_data) begin
                    errors++;
                    $display("FAIL R5 data moved while clock high: actual %b expected %b", ser_data, prev_data);
                end
            end
            prev_clk_hi = ser_clk;
            prev_data   = ser_data;
        end
    end

    task automatic wait_idle();
        do begin @(negedge clk); #2; end while (!exp_ready);
    endtask

    task automatic send(input logic [7:0] b, input logic [7:0] h, input logic [2:0] s,
                        input logic [7:0] g, input bit ones, input bit scr);
        wait_idle();
        in_data = b; cfg_half = h; cfg_stretch = s; cfg_gap = g; test_ones = ones;
        scramble_flag = scr; in_valid = 1;
        @(negedge clk); #2;
        in_valid = 0;
        if (scr) begin
            // R9: disturb every captured input mid-frame
            in_data = ~b; cfg_half = h + 8'd3; cfg_stretch = 3'd6;
            cfg_gap = g + 8'd5; test_ones = ~ones;
            in_valid = 0;
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        checks++;
        if ({in_ready, ser_clk, ser_data} !== 3'b111) begin
            errors++;
            $display("FAIL R1 in reset: actual %b expected 111", {in_ready, ser_clk, ser_data});
        end
        #2 rst_n = 1;
        @(negedge clk); #1;
        checks++;
        if ({in_ready, ser_clk, ser_data} !== 3'b111) begin
            errors++;
            $display("FAIL R1 after reset: actual %b expected 111", {in_ready, ser_clk, ser_data});
        end
        send(8'hA5, 8'd2, 3'd0, 8'd0, 0, 0);   // R2 R3 basic frame
        send(8'h3C, 8'd1, 3'd1, 8'd3, 0, 0);   // R4 x2, R6 gap
        send(8'h00, 8'd3, 3'd2, 8'd0, 1, 0);   // R8 all-ones override
        send(8'h81, 8'd1, 3'd7, 8'd2, 0, 0);   // R4 clamp to x16
        send(8'h5A, 8'd0, 3'd4, 8'd1, 0, 0);   // R3 half 0 acts as 1
        send(8'hC3, 8'd2, 3'd1, 8'd4, 0, 1);   // R9 scrambled mid-frame
        send(8'h17, 8'd1, 3'd3, 8'd0, 0, 0);
        // R7: valid held high across frames, busy periods ignore it
        wait_idle();
        in_data = 8'h6E; cfg_half = 8'd1; cfg_stretch = 3'd0; cfg_gap = 8'd1;
        test_ones = 0; scramble_flag = 0; in_valid = 1;
        repeat (70) @(negedge clk);
        #2 in_valid = 0;
        wait_idle();
        repeat (5) @(negedge clk);
        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL R7 watchdog: actual hung expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule